// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns one 32-bit logical address into a physical address, or reports a fault. An access is launched with a one-cycle start pulse. The start pulse carries the access attributes: supervisor or user, code or data, load or store, debug, and test. The block then pulses a done strobe. With the strobe it returns the physical address, the read/write/execute permissions, a fault flag and a test-status word. Descriptors are read through a simple request/ready memory port, and the port carries at most one transaction at a time. The same port writes back the used and modified status bits.

Translation may be switched off, in which case the address passes through unchanged. When translation is on, the block first tries a set of transparent windows. Each window is a register giving an address base, a don't-care mask, a privilege filter and a write-protect bit. If no window matches, the block walks three levels of tables, starting from the supervisor or the user root pointer: a root table, a pointer table and a page table. A page-table entry may point indirectly to the real page descriptor. Write protection collects across the levels. The page size is 4 KB or 8 KB.

Top module: `xlat_walker`

## Requirements
- R1: When `tc_enable` is 0, a started access completes on the next clock edge. It returns `xl_phys` equal to `xl_addr`, `xl_perm` 3'b111 and `xl_fault` 0, and it makes no memory request. `xl_perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R2: Window register layout: bits 31:24 are the base, bits 23:16 are the mask, bit 15 is the enable, bits 14:13 are the mode and bit 2 is write-protect. Mode 00 matches user accesses only, mode 01 matches supervisor accesses only, and mode 1x matches both. A window matches when it is enabled, the mode fits, and the address bits 31:24 equal the base in every bit whose mask bit is 0. When several windows match, the lowest-numbered one (lowest word of `tt_regs`) is used.
- R3: A window hit completes on the next edge with no memory request. It returns `xl_phys` = `xl_addr` and grants read and execute. It grants write only when the window's write-protect bit is 0. In test mode the status word is 32'h3; otherwise it is 0.
- R4: A walk starts at `srp` for supervisor accesses and at `urp` otherwise. The entry addresses are computed as follows, with 4-byte entries. The root entry is `root[31:9]` joined with address bits 31:25. The pointer entry is the root descriptor bits 31:9 joined with address bits 24:18. The page entry is the pointer descriptor bits 31:8 joined with address bits 17:12 for 4 KB pages, or bits 31:7 joined with address bits 17:13 for 8 KB pages.
- R5: Descriptor bit layout: bits 1:0 are the type, bit 2 is write-protect, bit 3 is used, bit 4 is modified and bit 7 is supervisor-only. A root or pointer descriptor whose bit 1 is 0 faults. A valid one whose used bit is 0 is written back with used set, unless the access is a debug access.
- R6: A write-protect bit at any level clears write permission. A store that meets one faults. An upper-level write-protect stops the walk at that level.
- R7: A page descriptor of type 2'b10 is indirect. Its bits 31:2 give the word address of the real page descriptor, which is read next. Any write-back goes to that address. A page descriptor of type 2'b00 faults.
- R8: A non-debug store to a page whose own write-protect bit is 0 writes back the descriptor with both used and modified set, unless both are already set. Other non-debug accesses write back only the used bit, when it is clear. A debug access never writes memory.
- R9: A user access to a supervisor-only page faults.
- R10: A successful walk returns the page descriptor with its low 12 bits (4 KB) or 13 bits (8 KB) cleared, ORed with the same low bits of the logical address. Permissions are read and execute, plus write when no level was write-protected.
- R11: For a successful test-mode walk the status word is built as follows. Bits 31:12 are the masked page base, bits 11:5 are copied from the descriptor, bit 4 is the descriptor's modified bit and bit 3 is its used bit, both as read. Bit 2 is the accumulated write-protect, bit 1 is 0 and bit 0 is 1. Outside test mode, and on any fault, the status word, `xl_phys` and `xl_perm` are all 0.
- R12: A memory response with `mem_err` set ends the walk with a fault.
- R13: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a cycle with `mem_ready`. There is no request while the block is idle, and `xl_done` is a single-cycle pulse.
- R14: When `acc_code` is set, `acc_store` is ignored, and the access is treated as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_start | input | 1 | Start pulse, taken only while idle |
| xl_addr | input | 32 | Logical address |
| acc_super | input | 1 | Supervisor access |
| acc_code | input | 1 | Instruction fetch |
| acc_store | input | 1 | Store access |
| acc_debug | input | 1 | Debug access, no write-back |
| acc_test | input | 1 | Test access, fills status word |
| tc_enable | input | 1 | Translation enable |
| tc_page8k | input | 1 | 1 = 8 KB pages, 0 = 4 KB |
| srp | input | 32 | Supervisor root pointer |
| urp | input | 32 | User root pointer |
| tt_regs | input | 64 | Transparent window registers, window 0 in the low word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Memory transaction complete |
| mem_err | input | 1 | Memory error, valid with ready |
| mem_rdata | input | 32 | Read data, valid with ready |
| xl_busy | output | 1 | Walk in progress |
| xl_done | output | 1 | Result valid pulse |
| xl_phys | output | 32 | Physical address |
| xl_perm | output | 3 | Permissions {exec, write, read} |
| xl_fault | output | 1 | Translation fault |
| xl_status | output | 32 | Test-status word |

## Verification
Some properties are checked on every cycle:
- the memory port holds its request until it is answered;
- debug walks never drive a write;
- every write-back carries the used bit;
- an error response ends the walk with a fault;
- the pass-through and window paths finish one edge after start without touching memory.

Other behaviour can only be shown through the bench's scenarios, which compare results and the memory image after each walk. This covers the exact entry addresses and descriptor values, the choice between the two roots, indirect fetches, 8 KB composition, write-protect accumulation, supervisor-only faults and the test-status layout.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

   // walk controller states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROOT_RD,
      ST_ROOT_WB,
      ST_PTR_RD,
      ST_PTR_WB,
      ST_PG_RD,
      ST_IND_RD,
      ST_PG_WB
   } walk_st_t;

   // latched access attributes (code accesses already folded into load)
   typedef struct packed {
      logic super_acc;
      logic store;
      logic debug;
      logic test;
   } acc_t;

   // descriptor bit positions
   localparam int DB_WP   = 2;
   localparam int DB_USED = 3;
   localparam int DB_MOD  = 4;
   localparam int DB_SUP  = 7;

   // transparent window register bit positions
   localparam int TW_EN      = 15;
   localparam int TW_MODE_HI = 14;
   localparam int TW_MODE_LO = 13;
   localparam int TW_WP      = 2;

endpackage

// File: rtl/xlat_tt_match.sv
`timescale 1ns/1ps
module xlat_tt_match #(
   parameter int ADDR_W = 32,
   parameter int BASE_W = 8
) (
   input  logic [ADDR_W-1:0] win_reg,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_super,
   output logic              hit,
   output logic              wprot
);
   import xlat_pkg::*;

   localparam int MASK_LSB = ADDR_W - 2*BASE_W;

   logic [BASE_W-1:0] base_f, mask_f, diff;
   logic              mode_ok;

   generate
      if (MASK_LSB <= TW_EN) begin : g_bad_layout
         $error("xlat_tt_match: base/mask fields overlap control bits");
      end
   endgenerate

   assign base_f  = win_reg[ADDR_W-1 -: BASE_W];
   assign mask_f  = win_reg[MASK_LSB +: BASE_W];
   assign diff    = (addr[ADDR_W-1 -: BASE_W] ^ base_f) & ~mask_f;
   assign mode_ok = win_reg[TW_MODE_HI] |
                    (win_reg[TW_MODE_LO] ? is_super : ~is_super);
   assign hit     = win_reg[TW_EN] & mode_ok & (diff == '0);
   assign wprot   = win_reg[TW_WP];

endmodule

// File: rtl/xlat_walk_fsm.sv
`timescale 1ns/1ps
module xlat_walk_fsm #(
   parameter int ADDR_W     = 32,
   parameter int ROOT_IDX_W = 7,
   parameter int PTR_IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  xlat_pkg::acc_t    acc,
   input  logic [ADDR_W-1:0] addr,
   input  logic              page8k,
   input  logic [ADDR_W-1:0] root_ptr,
   input  logic              bypass,
   input  logic [2:0]        byp_perm,
   input  logic [ADDR_W-1:0] byp_status,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic              mem_err,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] phys,
   output logic [2:0]        perm,
   output logic              fault,
   output logic [ADDR_W-1:0] status
);
   import xlat_pkg::*;

   localparam int PG4_SH    = 12;
   localparam int PG8_SH    = 13;
   localparam int PG4_IDX_W = ADDR_W - ROOT_IDX_W - PTR_IDX_W - PG4_SH;
   localparam int PG8_IDX_W = PG4_IDX_W - 1;
   localparam int PTR_MSB   = ADDR_W - 1 - ROOT_IDX_W;
   localparam int PG_MSB    = PTR_MSB - PTR_IDX_W;
   localparam logic [ADDR_W-1:0] ONES   = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] USED_M = ADDR_W'(1) << DB_USED;
   localparam logic [ADDR_W-1:0] MOD_M  = ADDR_W'(1) << DB_MOD;

   generate
      if (PG4_IDX_W < 2) begin : g_bad_split
         $error("xlat_walk_fsm: index fields leave no page index");
      end
   endgenerate

   walk_st_t          st, nx_st;
   acc_t              acc_q;
   logic [ADDR_W-1:0] a_q, ent_q, wd_q, d_q;
   logic [ADDR_W-1:0] nx_ent, nx_wd, nx_d;
   logic              wp_q, nx_wp, p8_q;

   logic              fin, fin_fault;
   logic [ADDR_W-1:0] fin_phys, fin_status;
   logic [2:0]        fin_perm;

   // index fields, zero extended
   logic [ADDR_W-1:0] ri_in, pi_q, gi4_q, gi8_q, root_ent_in;
   assign ri_in = {{(ADDR_W-ROOT_IDX_W){1'b0}}, addr[ADDR_W-1 -: ROOT_IDX_W]};
   assign pi_q  = {{(ADDR_W-PTR_IDX_W){1'b0}}, a_q[PTR_MSB -: PTR_IDX_W]};
   assign gi4_q = {{(ADDR_W-PG4_IDX_W){1'b0}}, a_q[PG_MSB -: PG4_IDX_W]};
   assign gi8_q = {{(ADDR_W-PG8_IDX_W){1'b0}}, a_q[PG_MSB -: PG8_IDX_W]};
   assign root_ent_in = (root_ptr & (ONES << (ROOT_IDX_W+2))) | (ri_in << 2);

   // upper-level continuation (after read or after write-back)
   logic              cu_wb, cu_is_root, cu_fault;
   logic [ADDR_W-1:0] cu_desc, cu_next_ent, pg_tbl_ent;
   assign cu_wb      = (st == ST_ROOT_WB) || (st == ST_PTR_WB);
   assign cu_is_root = (st == ST_ROOT_RD) || (st == ST_ROOT_WB);
   assign cu_desc    = cu_wb ? d_q : mem_rdata;
   assign pg_tbl_ent = p8_q ?
                       ((cu_desc & (ONES << (PG8_IDX_W+2))) | (gi8_q << 2)) :
                       ((cu_desc & (ONES << (PG4_IDX_W+2))) | (gi4_q << 2));
   assign cu_next_ent = cu_is_root ?
                       ((cu_desc & (ONES << (PTR_IDX_W+2))) | (pi_q << 2)) :
                       pg_tbl_ent;
   assign cu_fault   = cu_desc[DB_WP] & acc_q.store;

   // page-level evaluation
   logic              pg_wb_need, pg_wpall, pg_fault;
   logic [ADDR_W-1:0] pg_desc, pg_wb_val, pmask, pp, pf_status;
   assign pg_desc  = (st == ST_PG_WB) ? d_q : mem_rdata;
   assign pg_wpall = wp_q | pg_desc[DB_WP];
   assign pg_fault = (acc_q.store & pg_wpall) |
                     (pg_desc[DB_SUP] & ~acc_q.super_acc);
   assign pmask    = p8_q ? (ONES << PG8_SH) : (ONES << PG4_SH);
   assign pp       = pg_desc & pmask;

   always_comb begin
      pg_wb_need = 1'b0;
      pg_wb_val  = pg_desc | USED_M;
      if (!acc_q.debug) begin
         if (acc_q.store && !pg_desc[DB_WP]) begin
            pg_wb_need = !(pg_desc[DB_USED] && pg_desc[DB_MOD]);
            pg_wb_val  = pg_desc | USED_M | MOD_M;
         end else begin
            pg_wb_need = !pg_desc[DB_USED];
         end
      end
   end

   assign pf_status = acc_q.test ?
                      {pp[ADDR_W-1:PG4_SH], pg_desc[11:5], pg_desc[DB_MOD],
                       pg_desc[DB_USED], pg_wpall, 1'b0, 1'b1} : '0;

   always_comb begin
      nx_st      = st;
      nx_ent     = ent_q;
      nx_wd      = wd_q;
      nx_d       = d_q;
      nx_wp      = wp_q;
      fin        = 1'b0;
      fin_fault  = 1'b0;
      fin_phys   = '0;
      fin_perm   = '0;
      fin_status = '0;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               if (bypass) begin
                  fin        = 1'b1;
                  fin_phys   = addr;
                  fin_perm   = byp_perm;
                  fin_status = byp_status;
               end else begin
                  nx_st  = ST_ROOT_RD;
                  nx_ent = root_ent_in;
                  nx_wp  = 1'b0;
               end
            end
         end
         ST_ROOT_RD, ST_PTR_RD: begin
            if (mem_ready) begin
               if (mem_err || !mem_rdata[1]) begin
                  fin = 1'b1; fin_fault = 1'b1;
               end else begin
                  nx_d = mem_rdata;
                  if (!mem_rdata[DB_USED] && !acc_q.debug) begin
                     nx_st = (st == ST_ROOT_RD) ? ST_ROOT_WB : ST_PTR_WB;
                     nx_wd = mem_rdata | USED_M;
                  end else begin
                     nx_wp = wp_q | cu_desc[DB_WP];
                     if (cu_fault) begin
                        fin = 1'b1; fin_fault = 1'b1;
                     end else begin
                        nx_st  = cu_is_root ? ST_PTR_RD : ST_PG_RD;
                        nx_ent = cu_next_ent;
                     end
                  end
               end
            end
         end
         ST_ROOT_WB, ST_PTR_WB: begin
            if (mem_ready) begin
               nx_wp = wp_q | cu_desc[DB_WP];
               if (mem_err || cu_fault) begin
                  fin = 1'b1; fin_fault = 1'b1;
               end else begin
                  nx_st  = cu_is_root ? ST_PTR_RD : ST_PG_RD;
                  nx_ent = cu_next_ent;
               end
            end
         end
         ST_PG_RD, ST_IND_RD: begin
            if (mem_ready) begin
               if (mem_err || (st == ST_PG_RD && mem_rdata[1:0] == 2'b00)) begin
                  fin = 1'b1; fin_fault = 1'b1;
               end else if (st == ST_PG_RD && mem_rdata[1:0] == 2'b10) begin
                  nx_st  = ST_IND_RD;
                  nx_ent = {mem_rdata[ADDR_W-1:2], 2'b00};
               end else begin
                  nx_d = mem_rdata;
                  if (pg_wb_need) begin
                     nx_st = ST_PG_WB;
                     nx_wd = pg_wb_val;
                  end else begin
                     fin       = 1'b1;
                     fin_fault = pg_fault;
                     if (!pg_fault) begin
                        fin_phys   = pp | (a_q & ~pmask);
                        fin_perm   = {1'b1, ~pg_wpall, 1'b1};
                        fin_status = pf_status;
                     end
                  end
               end
            end
         end
         ST_PG_WB: begin
            if (mem_ready) begin
               fin       = 1'b1;
               fin_fault = mem_err | pg_fault;
               if (!fin_fault) begin
                  fin_phys   = pp | (a_q & ~pmask);
                  fin_perm   = {1'b1, ~pg_wpall, 1'b1};
                  fin_status = pf_status;
               end
            end
         end
         default: nx_st = ST_IDLE;
      endcase
      if (fin) nx_st = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         acc_q  <= '0;
         a_q    <= '0;
         ent_q  <= '0;
         wd_q   <= '0;
         d_q    <= '0;
         wp_q   <= 1'b0;
         p8_q   <= 1'b0;
         done   <= 1'b0;
         fault  <= 1'b0;
         phys   <= '0;
         perm   <= '0;
         status <= '0;
      end else begin
         st    <= nx_st;
         ent_q <= nx_ent;
         wd_q  <= nx_wd;
         d_q   <= nx_d;
         wp_q  <= nx_wp;
         done  <= fin;
         if (st == ST_IDLE && start) begin
            acc_q <= acc;
            a_q   <= addr;
            p8_q  <= page8k;
         end
         if (fin) begin
            fault  <= fin_fault;
            phys   <= fin_phys;
            perm   <= fin_perm;
            status <= fin_status;
         end
      end
   end

   assign busy      = (st != ST_IDLE);
   assign mem_req   = (st != ST_IDLE);
   assign mem_we    = (st == ST_ROOT_WB) || (st == ST_PTR_WB) || (st == ST_PG_WB);
   assign mem_addr  = ent_q;
   assign mem_wdata = wd_q;

   // R13
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));
   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   dbg_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && acc_q.debug |-> !mem_we);
   // R5
   wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[DB_USED]);
   // R12
   err_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready && mem_err |=> done && fault && !busy);

endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker #(
   parameter int ADDR_W     = 32,
   parameter int ROOT_IDX_W = 7,
   parameter int PTR_IDX_W  = 7,
   parameter int NUM_TT     = 2,
   parameter int TT_BASE_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     xl_start,
   input  logic [ADDR_W-1:0]        xl_addr,
   input  logic                     acc_super,
   input  logic                     acc_code,
   input  logic                     acc_store,
   input  logic                     acc_debug,
   input  logic                     acc_test,
   input  logic                     tc_enable,
   input  logic                     tc_page8k,
   input  logic [ADDR_W-1:0]        srp,
   input  logic [ADDR_W-1:0]        urp,
   input  logic [NUM_TT*ADDR_W-1:0] tt_regs,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [ADDR_W-1:0]        mem_wdata,
   input  logic                     mem_ready,
   input  logic                     mem_err,
   input  logic [ADDR_W-1:0]        mem_rdata,
   output logic                     xl_busy,
   output logic                     xl_done,
   output logic [ADDR_W-1:0]        xl_phys,
   output logic [2:0]               xl_perm,
   output logic                     xl_fault,
   output logic [ADDR_W-1:0]        xl_status
);
   import xlat_pkg::*;

   generate
      if (ADDR_W != 32) begin : g_bad_width
         $error("xlat_walker: status layout assumes a 32-bit address");
      end
      if (NUM_TT < 1) begin : g_bad_tt
         $error("xlat_walker: at least one transparent window required");
      end
   endgenerate

   logic [NUM_TT-1:0] tt_hit, tt_wpv;
   logic              tt_any, tt_wp, bypass;
   logic [2:0]        byp_perm;
   logic [ADDR_W-1:0] byp_status;
   acc_t              acc_in;

   generate
      for (genvar g = 0; g < NUM_TT; g++) begin : g_tt
         xlat_tt_match #(.ADDR_W(ADDR_W), .BASE_W(TT_BASE_W)) u_tt (
            .win_reg  (tt_regs[g*ADDR_W +: ADDR_W]),
            .addr     (xl_addr),
            .is_super (acc_super),
            .hit      (tt_hit[g]),
            .wprot    (tt_wpv[g])
         );
      end
   endgenerate

   // lowest-numbered matching window wins
   always_comb begin
      tt_any = 1'b0;
      tt_wp  = 1'b0;
      for (int g = NUM_TT-1; g >= 0; g--) begin
         if (tt_hit[g]) begin
            tt_any = 1'b1;
            tt_wp  = tt_wpv[g];
         end
      end
   end

   assign bypass     = ~tc_enable | tt_any;
   assign byp_perm   = tc_enable ? {1'b1, ~tt_wp, 1'b1} : 3'b111;
   assign byp_status = (tc_enable & acc_test) ? ADDR_W'(3) : '0;

   assign acc_in.super_acc = acc_super;
   assign acc_in.store     = acc_store & ~acc_code;
   assign acc_in.debug     = acc_debug;
   assign acc_in.test      = acc_test;

   xlat_walk_fsm #(
      .ADDR_W     (ADDR_W),
      .ROOT_IDX_W (ROOT_IDX_W),
      .PTR_IDX_W  (PTR_IDX_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (xl_start),
      .acc        (acc_in),
      .addr       (xl_addr),
      .page8k     (tc_page8k),
      .root_ptr   (acc_super ? srp : urp),
      .bypass     (bypass),
      .byp_perm   (byp_perm),
      .byp_status (byp_status),
      .busy       (xl_busy),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ready  (mem_ready),
      .mem_err    (mem_err),
      .mem_rdata  (mem_rdata),
      .done       (xl_done),
      .phys       (xl_phys),
      .perm       (xl_perm),
      .fault      (xl_fault),
      .status     (xl_status)
   );

   // R1
   disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_start && !xl_busy && !tc_enable |=>
         xl_done && !xl_fault && xl_perm == 3'b111 &&
         xl_phys == $past(xl_addr) && !mem_req);
   // R3
   tt_nowalk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_start && !xl_busy && tc_enable && tt_any |=>
         xl_done && !xl_fault && !mem_req && xl_perm[0] && xl_perm[2]);

endmodule

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xl_start = 1'b0;
   logic [31:0] xl_addr = '0;
   logic        acc_super = 1'b0, acc_code = 1'b0, acc_store = 1'b0;
   logic        acc_debug = 1'b0, acc_test = 1'b0;
   logic        tc_enable = 1'b1, tc_page8k = 1'b0;
   logic [31:0] srp = 32'h0, urp = 32'h200;
   logic [63:0] tt_regs = '0;
   logic        mem_req, mem_we, mem_ready, mem_err;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        xl_busy, xl_done, xl_fault;
   logic [31:0] xl_phys, xl_status;
   logic [2:0]  xl_perm;

   always #2.5 clk = ~clk;

   xlat_walker u0 (
      .clk(clk), .rst_n(rst_n), .xl_start(xl_start), .xl_addr(xl_addr),
      .acc_super(acc_super), .acc_code(acc_code), .acc_store(acc_store),
      .acc_debug(acc_debug), .acc_test(acc_test), .tc_enable(tc_enable),
      .tc_page8k(tc_page8k), .srp(srp), .urp(urp), .tt_regs(tt_regs),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_err(mem_err),
      .mem_rdata(mem_rdata), .xl_busy(xl_busy), .xl_done(xl_done),
      .xl_phys(xl_phys), .xl_perm(xl_perm), .xl_fault(xl_fault),
      .xl_status(xl_status)
   );

   // memory model: answers each request one cycle later
   logic [31:0] mem [0:1023];
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         mem_err   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ready) begin
         mem_ready <= 1'b1;
         mem_err   <= (mem_addr == err_addr);
         mem_rdata <= mem[mem_addr[11:2]];
         if (mem_we && mem_addr != err_addr) mem[mem_addr[11:2]] <= mem_wdata;
      end else begin
         mem_ready <= 1'b0;
         mem_err   <= 1'b0;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   typedef struct {
      logic [31:0] phys;
      logic [2:0]  perm;
      logic        fault;
      logic [31:0] status;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   // monitor: pops and compares on every result
   always @(negedge clk) begin
      if (rst_n && xl_done) begin
         if (exp_q.size() == 0) begin
            chk("R13 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.req, " phys"},   xl_phys, e.phys);
            chk({e.req, " perm"},   {29'd0, xl_perm}, {29'd0, e.perm});
            chk({e.req, " fault"},  {31'd0, xl_fault}, {31'd0, e.fault});
            chk({e.req, " status"}, xl_status, e.status);
         end
      end
   end

   // driver: queue the expectation, pulse start, wait for the result
   task automatic go(input logic [31:0] a, input bit sup, input bit code,
                     input bit st, input bit dbg, input bit tst,
                     input logic [31:0] e_phys, input logic [2:0] e_perm,
                     input bit e_fault, input logic [31:0] e_stat, input string req);
      exp_t e;
      e.phys = e_phys; e.perm = e_perm; e.fault = e_fault;
      e.status = e_stat; e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      xl_addr = a; acc_super = sup; acc_code = code; acc_store = st;
      acc_debug = dbg; acc_test = tst; xl_start = 1'b1;
      @(negedge clk);
      xl_start = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[11:2]];
   endfunction

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      mem['h004 >> 2] = 32'h0000_0402;   // supervisor root idx 1 -> ptr table 0x400
      mem['h204 >> 2] = 32'h0000_040A;   // user root idx 1, used already set
      mem['h40C >> 2] = 32'h0000_0602;   // ptr idx 3 -> page table 0x600
      mem['h410 >> 2] = 32'h0000_060E;   // ptr idx 4, write-protected, used
      mem['h614 >> 2] = 32'h0012_3001;   // page 5
      mem['h618 >> 2] = 32'h0045_6001;   // page 6
      mem['h61C >> 2] = 32'h0000_0802;   // page 7 indirect -> 0x800
      mem['h624 >> 2] = 32'h00AA_A009;   // page 9, used, not modified
      mem['h628 >> 2] = 32'h00BB_B005;   // page 10, write-protected
      mem['h800 >> 2] = 32'h0078_9081;   // supervisor-only page

      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 reset busy", {31'd0, xl_busy}, 32'd0);
      chk("R13 reset done", {31'd0, xl_done}, 32'd0);
      chk("R13 reset req",  {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R5 R8 R10: first load walk writes used bits at every level
      go(32'h020C_5123, 1,0,0,0,0, 32'h0012_3123, 3'b111, 0, 32'h0, "R4 R10 load walk");
      chk("R5 root used wb", rd(32'h004), 32'h0000_040A);
      chk("R5 ptr used wb",  rd(32'h40C), 32'h0000_060A);
      chk("R8 page used wb", rd(32'h614), 32'h0012_3009);

      // R8 R11: test-mode store sets modified
      go(32'h020C_5123, 1,0,1,0,1, 32'h0012_3123, 3'b111, 0, 32'h0012_3009, "R11 test store");
      chk("R8 store sets mod", rd(32'h614), 32'h0012_3019);

      // R8 debug store: no write-back
      go(32'h020C_6000, 1,0,1,1,0, 32'h0045_6000, 3'b111, 0, 32'h0, "R8 debug store");
      chk("R8 debug no wb", rd(32'h618), 32'h0045_6001);

      // R6 upper-level write-protect
      go(32'h0210_5000, 1,0,0,0,1, 32'h0012_3000, 3'b101, 0, 32'h0012_301D, "R6 R11 wp load");
      go(32'h0210_5000, 1,0,1,0,0, 32'h0, 3'b000, 1, 32'h0, "R6 wp store fault");
      chk("R6 no page wb", rd(32'h614), 32'h0012_3019);

      // R6 page-level write-protect: used only, then fault
      go(32'h020C_A000, 1,0,1,0,0, 32'h0, 3'b000, 1, 32'h0, "R6 page wp store");
      chk("R8 wp page used only", rd(32'h628), 32'h00BB_B00D);

      // R7 indirect
      go(32'h020C_7000, 1,0,0,0,0, 32'h0078_9000, 3'b111, 0, 32'h0, "R7 indirect");
      chk("R7 wb at target", rd(32'h800), 32'h0078_9089);
      chk("R7 entry kept",   rd(32'h61C), 32'h0000_0802);

      // R9 R4: user root, supervisor-only page
      go(32'h020C_7000, 0,0,0,0,0, 32'h0, 3'b000, 1, 32'h0, "R9 user sup page");

      // R5 invalid root, R7 invalid page
      go(32'h0400_0000, 1,0,0,0,0, 32'h0, 3'b000, 1, 32'h0, "R5 invalid root");
      go(32'h020C_8000, 1,0,0,0,0, 32'h0, 3'b000, 1, 32'h0, "R7 invalid page");

      // R14 code fetch ignores store
      go(32'h020C_9000, 1,1,1,0,0, 32'h00AA_A000, 3'b111, 0, 32'h0, "R14 code store");
      chk("R14 no mod wb", rd(32'h624), 32'h00AA_A009);

      // R10 8 KB pages
      tc_page8k = 1'b1;
      go(32'h020C_BABC, 1,0,0,0,0, 32'h0012_3ABC, 3'b111, 0, 32'h0, "R10 8k page");
      tc_page8k = 1'b0;

      // R12 memory error
      err_addr = 32'h40C;
      go(32'h020C_5000, 1,0,0,0,0, 32'h0, 3'b000, 1, 32'h0, "R12 mem error");
      err_addr = 32'hFFFF_FFFF;

      // R2 R3 transparent windows
      tt_regs[31:0]  = 32'h8000_C000;   // base 80, mask 00, any mode
      tt_regs[63:32] = 32'h901F_A004;   // base 90, mask 1F, supervisor, wp
      go(32'h9A00_0040, 1,0,0,0,1, 32'h9A00_0040, 3'b101, 0, 32'h3, "R3 wp window");
      go(32'h8000_1234, 1,0,1,0,0, 32'h8000_1234, 3'b111, 0, 32'h0, "R2 priority");
      go(32'h8000_1234, 0,0,0,0,1, 32'h8000_1234, 3'b111, 0, 32'h3, "R2 any mode");
      go(32'h9A00_0040, 0,0,0,0,0, 32'h0, 3'b000, 1, 32'h0, "R2 mode filter");
      tt_regs = '0;

      // R1 disabled pass-through
      tc_enable = 1'b0;
      go(32'h1234_5678, 0,0,1,0,1, 32'h1234_5678, 3'b111, 0, 32'h0, "R1 disabled");
      tc_enable = 1'b1;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule